// File: doc/BRIEF.md
# Capacitor Array Reconfiguration Sequencer

This block is the digital controller beside a switched-capacitor energy reservoir made of unit capacitors. In delivery mode it walks a fixed schedule of switch configurations. It starts with all capacitors in parallel. Next comes a split phase, which pairs high-voltage capacitors with low-voltage ones to build a voltage gradient. Last come two recombine rounds, in which two stacks are shifted in opposite directions. The sequencer advances by one configuration each time a clocked comparator reports that the supply has dropped below its minimum. In charging mode it replays the recombine configurations in reverse order, and advances each time the stacked voltage reaches the battery level.

Each configuration drives one bit in one of three switch groups: split, first recombine round and second recombine round. It also drives one bit of a rail-connection group. Every change of configuration passes through one cycle with all switches open. After a configuration is applied, comparator pulses are ignored for a programmable number of cycles so that the supply can recover. All pins are plain control and status levels; the block has no data stream and no handshake.

Top module: `capseq_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the block is in delivery mode at configuration 0. In that configuration only rail bit 0 is set, every other group is zero, depleted_o is 0 and the skip length is 2.
- R2: In delivery mode, each rising edge of below_min_i that is taken advances the schedule by exactly one configuration. A level held high causes no further advance, and at_batt_i has no effect in delivery mode.
- R3: An accepted step produces exactly one cycle in which all switch outputs are zero. The new configuration appears on the cycle after that.
- R4: After a configuration is applied, trigger edges in the next skip-length cycles are dropped and not queued. skip_wr_i loads skip_val_i as the new length, and a length of 0 disables the window.
- R5: With the default parameters the delivery order is as follows. Configuration 0 sets rail bit 0. Split sub-steps 1..6 set split bit k-1 and rail bit 1; steps 1 and 2 are time-spread into two sub-steps each, and step 3 has two. Shifts 7..14 set rc1 bit k-7 and rail bit 2. Shifts 15..18 set rc2 bit k-15 and rail bit 3.
- R6: A trigger taken at the last delivery configuration sets depleted_o and leaves the switches unchanged, with no open cycle. depleted_o then stays set.
- R7: When mode_chg_i goes to 1, the block passes through one open cycle and enters charging. There it replays the recombine configurations in reverse order, from rc2 bit 3 down to rc1 bit 0, with rail bit 4 set. Each accepted rising edge of at_batt_i advances one step, and below_min_i has no effect.
- R8: When mode_chg_i returns to 0, the block passes through one open cycle, restarts at delivery configuration 0 and clears depleted_o.
- R9: Outside an open cycle, exactly one rail bit is set and at most one bit is set across the split, rc1 and rc2 groups.
- R10: At the last charging configuration, further at_batt_i edges leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_chg_i | input | 1 | 1 selects charging, 0 selects delivery |
| below_min_i | input | 1 | Comparator: supply is below the minimum |
| at_batt_i | input | 1 | Comparator: stacked voltage has reached the battery level |
| skip_wr_i | input | 1 | Load strobe for the skip length |
| skip_val_i | input | SKIP_W | New skip length |
| split_en_o | output | SPLIT_W | Split-phase switch enables |
| rc1_en_o | output | RC1_W | First recombine round enables |
| rc2_en_o | output | RC2_W | Second recombine round enables |
| rail_en_o | output | RAIL_W | Supply and ground connection enables |
| depleted_o | output | 1 | Delivery schedule exhausted |

## Verification
The bench builds the block with its default parameters. These are three split steps, two of them time-spread, eight first-round shifts, four second-round shifts, and a skip length of 2. With these values all nineteen delivery configurations, the depleted state and all twelve charging steps can be reached in a few hundred cycles. The bench also reloads the skip length to 0 to reach back-to-back steps, and checks that a reset returns the length to 2.

// File: rtl/capseq_pkg.sv
package capseq_pkg;
  typedef enum logic [1:0] {GRP_NONE, GRP_SPLIT, GRP_RC1, GRP_RC2} grp_e;

  // Number of trigger events in the split phase: step 1 is a single pairing,
  // step j>=2 has 2^(j-2) sub-steps, and time-spread steps double their count.
  function automatic int split_events(int steps, int spread);
    int tot;
    int base;
    tot = 0;
    for (int j = 1; j <= steps; j++) begin
      base = (j == 1) ? 1 : (1 << (j - 2));
      tot += (j <= spread) ? 2 * base : base;
    end
    return tot;
  endfunction
endpackage

// File: rtl/capseq_trig.sv
module capseq_trig #(
  parameter int              SKIP_W   = 3,
  parameter logic [SKIP_W-1:0] SKIP_DEF = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_i,
  input  logic              apply_i,
  input  logic              hold_i,
  input  logic              skip_wr_i,
  input  logic [SKIP_W-1:0] skip_val_i,
  output logic              fire_o,
  output logic              window_o
);
  logic              prev_q;
  logic [SKIP_W-1:0] len_q;
  logic [SKIP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      len_q  <= SKIP_DEF;
      cnt_q  <= '0;
    end else begin
      prev_q <= raw_i;
      if (skip_wr_i) len_q <= skip_val_i;
      if (apply_i)            cnt_q <= len_q;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign window_o = (cnt_q != '0);
  assign fire_o   = raw_i & ~prev_q & ~window_o & ~hold_i;

  // R2
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  // R4
  window_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i && (len_q != '0) && !skip_wr_i |=> window_o);
endmodule

// File: rtl/capseq_ctrl.sv
module capseq_ctrl #(
  parameter int IDX_W    = 5,
  parameter int DLV_LAST = 18,
  parameter int CHG_LAST = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             fire_i,
  output logic             chg_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             bbm_q,
  output logic             depleted_q,
  output logic             apply_o,
  output logic             restart_o
);
  logic [IDX_W-1:0] tgt_q;
  logic             at_end;

  assign restart_o = (mode_i != chg_q);
  assign at_end    = chg_q ? (idx_q == IDX_W'(CHG_LAST)) : (idx_q == IDX_W'(DLV_LAST));
  assign apply_o   = bbm_q & ~restart_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_q      <= 1'b0;
      idx_q      <= '0;
      tgt_q      <= '0;
      bbm_q      <= 1'b0;
      depleted_q <= 1'b0;
    end else if (restart_o) begin
      chg_q      <= mode_i;
      tgt_q      <= '0;
      bbm_q      <= 1'b1;
      depleted_q <= 1'b0;
    end else if (bbm_q) begin
      idx_q <= tgt_q;
      bbm_q <= 1'b0;
    end else if (fire_i) begin
      if (at_end) begin
        if (!chg_q) depleted_q <= 1'b1;
      end else begin
        tgt_q <= idx_q + 1'b1;
        bbm_q <= 1'b1;
      end
    end
  end

  // R3
  bbm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bbm_q && !restart_o |=> !bbm_q);

  // R6
  depleted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depleted_q && !restart_o |=> depleted_q);

  // R6
  depleted_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depleted_q |-> !chg_q && !bbm_q && (idx_q == IDX_W'(DLV_LAST)));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> (idx_q == $past(idx_q) + 1'b1) || (idx_q == '0));
endmodule

// File: rtl/capseq_dec.sv
module capseq_dec
  import capseq_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int SPLIT_W = 22,
  parameter int RC1_W   = 60,
  parameter int RC2_W   = 13,
  parameter int RAIL_W  = 24,
  parameter int SPLIT_N = 6,
  parameter int RC1_N   = 8,
  parameter int RC2_N   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chg_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               bbm_i,
  output logic [SPLIT_W-1:0] split_en_o,
  output logic [RC1_W-1:0]   rc1_en_o,
  output logic [RC2_W-1:0]   rc2_en_o,
  output logic [RAIL_W-1:0]  rail_en_o
);
  localparam int RAIL_PAR = 0;
  localparam int RAIL_SPL = 1;
  localparam int RAIL_RC1 = 2;
  localparam int RAIL_RC2 = 3;
  localparam int RAIL_CHG = 4;

  grp_e grp;
  int   pos;
  int   rail_sel;
  int   iv;
  int   rec;

  always_comb begin
    grp      = GRP_NONE;
    pos      = 0;
    rail_sel = RAIL_PAR;
    iv       = int'(idx_i);
    rec      = 0;
    if (!chg_i) begin
      if (iv == 0) begin
        rail_sel = RAIL_PAR;
      end else if (iv <= SPLIT_N) begin
        grp = GRP_SPLIT; pos = iv - 1; rail_sel = RAIL_SPL;
      end else if (iv <= SPLIT_N + RC1_N) begin
        grp = GRP_RC1; pos = iv - 1 - SPLIT_N; rail_sel = RAIL_RC1;
      end else begin
        grp = GRP_RC2; pos = iv - 1 - SPLIT_N - RC1_N; rail_sel = RAIL_RC2;
      end
    end else begin
      rec      = RC1_N + RC2_N - 1 - iv;
      rail_sel = RAIL_CHG;
      if (rec < RC1_N) begin
        grp = GRP_RC1; pos = rec;
      end else begin
        grp = GRP_RC2; pos = rec - RC1_N;
      end
    end
  end

  for (genvar k = 0; k < SPLIT_W; k++) begin : g_split
    assign split_en_o[k] = !bbm_i && (grp == GRP_SPLIT) && (pos == k);
  end
  for (genvar k = 0; k < RC1_W; k++) begin : g_rc1
    assign rc1_en_o[k] = !bbm_i && (grp == GRP_RC1) && (pos == k);
  end
  for (genvar k = 0; k < RC2_W; k++) begin : g_rc2
    assign rc2_en_o[k] = !bbm_i && (grp == GRP_RC2) && (pos == k);
  end
  for (genvar k = 0; k < RAIL_W; k++) begin : g_rail
    assign rail_en_o[k] = !bbm_i && (rail_sel == k);
  end

  // R9
  grp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bbm_i |-> $onehot(rail_en_o) && ($countones({split_en_o, rc1_en_o, rc2_en_o}) <= 1));
endmodule

// File: rtl/capseq_top.sv
module capseq_top
  import capseq_pkg::*;
#(
  parameter int              SPLIT_W     = 22,
  parameter int              RC1_W       = 60,
  parameter int              RC2_W       = 13,
  parameter int              RAIL_W      = 24,
  parameter int              SPLIT_STEPS = 3,
  parameter int              SPREAD_STEPS = 2,
  parameter int              RC1_N       = 8,
  parameter int              RC2_N       = 4,
  parameter int              SKIP_W      = 3,
  parameter logic [SKIP_W-1:0] SKIP_DEF  = 3'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_chg_i,
  input  logic               below_min_i,
  input  logic               at_batt_i,
  input  logic               skip_wr_i,
  input  logic [SKIP_W-1:0]  skip_val_i,
  output logic [SPLIT_W-1:0] split_en_o,
  output logic [RC1_W-1:0]   rc1_en_o,
  output logic [RC2_W-1:0]   rc2_en_o,
  output logic [RAIL_W-1:0]  rail_en_o,
  output logic               depleted_o
);
  localparam int SPLIT_N  = split_events(SPLIT_STEPS, SPREAD_STEPS);
  localparam int DLV_LAST = SPLIT_N + RC1_N + RC2_N;
  localparam int CHG_LAST = RC1_N + RC2_N - 1;
  localparam int IDX_W    = $clog2(DLV_LAST + 1);

  logic             chg;
  logic [IDX_W-1:0] idx;
  logic             bbm;
  logic             apply;
  logic             restart;
  logic             fire;
  logic             window;
  logic             raw;

  assign raw = chg ? at_batt_i : below_min_i;

  capseq_trig #(.SKIP_W(SKIP_W), .SKIP_DEF(SKIP_DEF)) u_trig (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .apply_i(apply), .hold_i(bbm),
    .skip_wr_i(skip_wr_i), .skip_val_i(skip_val_i),
    .fire_o(fire), .window_o(window)
  );

  capseq_ctrl #(.IDX_W(IDX_W), .DLV_LAST(DLV_LAST), .CHG_LAST(CHG_LAST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_chg_i), .fire_i(fire),
    .chg_q(chg), .idx_q(idx), .bbm_q(bbm), .depleted_q(depleted_o),
    .apply_o(apply), .restart_o(restart)
  );

  capseq_dec #(
    .IDX_W(IDX_W), .SPLIT_W(SPLIT_W), .RC1_W(RC1_W), .RC2_W(RC2_W), .RAIL_W(RAIL_W),
    .SPLIT_N(SPLIT_N), .RC1_N(RC1_N), .RC2_N(RC2_N)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .chg_i(chg), .idx_i(idx), .bbm_i(bbm),
    .split_en_o(split_en_o), .rc1_en_o(rc1_en_o), .rc2_en_o(rc2_en_o), .rail_en_o(rail_en_o)
  );

  // R4
  skip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window && !bbm && !restart |=> !bbm);
endmodule

// File: tb/sim_capseq_top.sv
`timescale 1ns/1ps
module sim_capseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_chg = 1'b0;
  logic        below_min = 1'b0;
  logic        at_batt = 1'b0;
  logic        skip_wr = 1'b0;
  logic [2:0]  skip_val = 3'd0;
  logic [21:0] split_en;
  logic [59:0] rc1_en;
  logic [12:0] rc2_en;
  logic [23:0] rail_en;
  logic        depleted;

  int checks = 0;
  int errors = 0;
  logic [119:0] mid_v, post_v;

  always #2.5 clk = ~clk;

  capseq_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_chg_i(mode_chg), .below_min_i(below_min),
    .at_batt_i(at_batt), .skip_wr_i(skip_wr), .skip_val_i(skip_val),
    .split_en_o(split_en), .rc1_en_o(rc1_en), .rc2_en_o(rc2_en),
    .rail_en_o(rail_en), .depleted_o(depleted)
  );

  // {rail[2:0], group[1:0], position[5:0]} for each delivery configuration
  localparam logic [10:0] SCHED [19] = '{
    11'd0,
    11'd320, 11'd321, 11'd322, 11'd323, 11'd324, 11'd325,
    11'd640, 11'd641, 11'd642, 11'd643, 11'd644, 11'd645, 11'd646, 11'd647,
    11'd960, 11'd961, 11'd962, 11'd963
  };

  function automatic logic [119:0] obs();
    return {depleted, rail_en, rc2_en, rc1_en, split_en};
  endfunction

  function automatic logic [119:0] ev(int rail, logic [10:0] e, bit dep);
    logic [119:0] v;
    int p;
    v = '0;
    v[119] = dep;
    v[95 + rail] = 1'b1;
    p = int'(e[5:0]);
    case (e[7:6])
      2'd1: v[p] = 1'b1;
      2'd2: v[22 + p] = 1'b1;
      2'd3: v[82 + p] = 1'b1;
      default: ;
    endcase
    return v;
  endfunction

  task automatic chk(string req, logic [119:0] act, logic [119:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: one-cycle pulse, samples after the next two edges.
  task automatic pulse(bit use_batt);
    if (use_batt) at_batt = 1'b1; else below_min = 1'b1;
    @(negedge clk);
    at_batt = 1'b0; below_min = 1'b0;
    mid_v = obs();
    @(negedge clk);
    post_v = obs();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset state", obs(), ev(0, SCHED[0], 0));

    // R2/R7: at_batt in delivery mode has no effect
    idle(3);
    pulse(1'b1);
    chk("R2 at_batt ignored mid", mid_v, ev(0, SCHED[0], 0));
    chk("R2 at_batt ignored post", post_v, ev(0, SCHED[0], 0));

    // R5/R3: walk the delivery schedule from the table
    for (int i = 1; i < 19; i++) begin
      idle(3);
      pulse(1'b0);
      chk("R3 open cycle", mid_v, '0);
      chk("R5 delivery order", post_v, ev(int'(SCHED[i][10:8]), SCHED[i], 0));
    end

    // R6: trigger at last configuration
    idle(3);
    pulse(1'b0);
    chk("R6 depleted no open cycle", mid_v, ev(3, SCHED[18], 1));
    chk("R6 depleted hold", post_v, ev(3, SCHED[18], 1));

    // R7: enter charging
    mode_chg = 1'b1;
    @(negedge clk);
    chk("R7 restart open cycle", obs(), '0);
    @(negedge clk);
    chk("R7 charge first", obs(), ev(4, SCHED[18], 0));
    idle(3);
    pulse(1'b0);
    chk("R7 below_min ignored", post_v, ev(4, SCHED[18], 0));
    for (int c = 1; c < 12; c++) begin
      idle(3);
      pulse(1'b1);
      chk("R7 charge open cycle", mid_v, '0);
      chk("R7 charge reverse order", post_v, ev(4, SCHED[18 - c], 0));
    end

    // R10: extra at_batt at end of charging
    idle(3);
    pulse(1'b1);
    chk("R10 charge end mid", mid_v, ev(4, SCHED[7], 0));
    chk("R10 charge end post", post_v, ev(4, SCHED[7], 0));

    // R8: back to delivery
    mode_chg = 1'b0;
    @(negedge clk);
    chk("R8 restart open cycle", obs(), '0);
    @(negedge clk);
    chk("R8 restart config0", obs(), ev(0, SCHED[0], 0));

    // R4: edge inside skip window is dropped, not queued
    idle(3);
    pulse(1'b0);
    chk("R4 step1", post_v, ev(1, SCHED[1], 0));
    pulse(1'b0);
    chk("R4 dropped in window", post_v, ev(1, SCHED[1], 0));
    idle(5);
    chk("R4 not queued", obs(), ev(1, SCHED[1], 0));

    // R2: held level gives no further step
    pulse(1'b0);
    chk("R2 step2", post_v, ev(1, SCHED[2], 0));
    below_min = 1'b1;
    idle(6);
    chk("R2 held level", obs(), ev(1, SCHED[2], 0));
    below_min = 1'b0;

    // R4: reload skip length to 0, back-to-back steps taken
    skip_val = 3'd0;
    skip_wr = 1'b1;
    @(negedge clk);
    skip_wr = 1'b0;
    idle(3);
    pulse(1'b0);
    chk("R4 step3", post_v, ev(1, SCHED[3], 0));
    pulse(1'b0);
    chk("R4 zero window open cycle", mid_v, '0);
    chk("R4 zero window step4", post_v, ev(1, SCHED[4], 0));

    // R1: synchronous reset mid-run restores config0 and skip length 2
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset mid-run", obs(), ev(0, SCHED[0], 0));
    idle(2);
    pulse(1'b0);
    chk("R1 step after reset", post_v, ev(1, SCHED[1], 0));
    pulse(1'b0);
    chk("R1 skip default restored", post_v, ev(1, SCHED[1], 0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule